// File: doc/BRIEF.md
# In-Order Dual-Issue Pairing Stage

This block is the issue stage of an in-order two-way superscalar core that has one integer pipe and one floating-point pipe. Each clock it receives a 64-bit fetch packet holding two 32-bit instruction slots, together with a valid bit per slot. It decodes the class and the three register numbers of each slot and decides whether zero, one or two instructions leave for the pipes this cycle.

The first slot (packet bits 31:0) may only feed the integer pipe and the second slot (bits 63:32) may only feed the FP pipe. The second slot never issues unless the first one issues in the same cycle. Operand readiness comes from two external busy vectors, one per register file. An FP load sits on the integer side and may pair with an FP operation, which is why the FP register file needs extra ports.

The number of slots consumed is reported in the same cycle so the fetch buffer can advance by exactly that amount. The issued instruction words and their valids are registered toward the pipes.

Top module: `pair_issue`

## Requirements
- R1: While reset is asserted and on the first cycles after it with no valid slot, `intIssueValid` and `fpIssueValid` are 0 and `issueCount` is 0.
- R2: An instruction word is decoded as opcode bits 31:26, destination bits 25:21, source A bits 20:16 and source B bits 15:11. Bit 31 set means FP class (an FP operation: it reads and writes FP registers). Bit 31 clear means integer class. Within the integer class, bit 30 set means FP load: it reads integer source A and writes an FP destination, and source B is unused.
- R3: A valid integer-class instruction in slot 0 whose sources are not busy issues. `issueCount` is at least 1 in that same cycle. On the next cycle `intIssueValid` is 1 and `intIssueInstr` holds the slot-0 word.
- R4: When slot 0 issues and slot 1 holds a valid, ready FP-class instruction with no same-packet dependency, both issue. `issueCount` is 2. On the next cycle both pipe valids are 1 and `fpIssueInstr` holds the slot-1 word.
- R5: Slot 1 never issues when slot 0 does not issue, even if slot 1 is itself ready.
- R6: A slot holding the wrong class for its position (FP class in slot 0, integer class in slot 1) does not issue. Wrong class in slot 0 gives a count of 0. Wrong class in slot 1 gives a count of 1.
- R7: Source readiness is checked per class. An integer ALU instruction checks source A and source B in the integer busy vector. An FP load checks only source A in the integer busy vector, so a busy source B has no effect on it. An FP operation checks both sources in the FP busy vector. A busy checked source blocks that slot and everything behind it.
- R8: An FP load in slot 0 pairs with an FP operation in slot 1 when they are independent (count 2). The pair is refused (count 1) when the FP operation reads the load's destination through either source.
- R9: An integer ALU destination equal in number to an FP operation source is not a dependency, because the two use different register files, so the pair issues.
- R10: A slot with its valid bit clear does not issue. A clear slot-0 valid gives a count of 0 whatever slot 1 holds.
- R11: `issueCount` is 0, 1 or 2, is valid in the same cycle as the packet, and equals the number of pipe valids raised on the next cycle. A cycle with no issue drops both valids on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotValid | input | 2 | Per-slot valid, bit 0 for slot 0 |
| fetchPacket | input | 64 | Slot 0 in bits 31:0, slot 1 in bits 63:32 |
| intBusy | input | 32 | Integer register busy flags, one per register |
| fpBusy | input | 32 | FP register busy flags, one per register |
| issueCount | output | 2 | Slots consumed this cycle (0, 1 or 2) |
| intIssueValid | output | 1 | Registered issue valid toward the integer pipe |
| intIssueInstr | output | 32 | Registered instruction word for the integer pipe |
| fpIssueValid | output | 1 | Registered issue valid toward the FP pipe |
| fpIssueInstr | output | 32 | Registered instruction word for the FP pipe |

## Verification
The bench builds the block with the package defaults: 32-bit instruction words, two slots and 32 registers per file. With these values every register number fits the 5-bit fields, so a busy flag can be placed on any single source while its twin stays free. This makes it possible to show that an FP load ignores source B while an integer ALU instruction does not. It also lets equal register numbers be put in different files, so a same-number pair across files can be told apart from a true FP load dependency.

// File: rtl/pair_pkg.sv
package pair_pkg;
  parameter int INSTR_W  = 32;
  parameter int NUM_REGS = 32;
  localparam int REG_W    = $clog2(NUM_REGS);
  localparam int OPC_W    = 6;
  localparam int SLOTS    = 2;
  localparam int PACKET_W = INSTR_W * SLOTS;
  localparam int OPC_LSB  = INSTR_W - OPC_W;
  localparam int DST_LSB  = OPC_LSB - REG_W;
  localparam int SRCA_LSB = DST_LSB - REG_W;
  localparam int SRCB_LSB = SRCA_LSB - REG_W;

  typedef struct packed {
    logic             isFp;
    logic             isFpLoad;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] srcA;
    logic [REG_W-1:0] srcB;
  } slotDec_t;

  typedef struct packed {
    logic [SLOTS-1:0] present;
    logic [SLOTS-1:0] classOk;
    logic [SLOTS-1:0] srcReady;
    logic             crossDep;
  } pairFlags_t;

  typedef struct packed {
    logic loadInt;
    logic loadFp;
  } issueStrobe_t;

  function automatic slotDec_t decodeSlot(input logic [INSTR_W-1:0] w);
    slotDec_t d;
    d.isFp     = w[INSTR_W-1];
    d.isFpLoad = !w[INSTR_W-1] && w[INSTR_W-2];
    d.dst      = w[DST_LSB  +: REG_W];
    d.srcA     = w[SRCA_LSB +: REG_W];
    d.srcB     = w[SRCB_LSB +: REG_W];
    return d;
  endfunction
endpackage

// File: rtl/pair_datapath.sv
module pair_datapath
  import pair_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [SLOTS-1:0]    slotValid,
  input  logic [PACKET_W-1:0] fetchPacket,
  input  logic [NUM_REGS-1:0] intBusy,
  input  logic [NUM_REGS-1:0] fpBusy,
  input  issueStrobe_t        strobe,
  output pairFlags_t          flags,
  output logic                intIssueValid,
  output logic [INSTR_W-1:0]  intIssueInstr,
  output logic                fpIssueValid,
  output logic [INSTR_W-1:0]  fpIssueInstr
);
  logic [INSTR_W-1:0] slotWord [SLOTS];
  slotDec_t           dec      [SLOTS];
  logic [SLOTS-1:0]   classOkV;
  logic [SLOTS-1:0]   readyV;
  logic               crossDep;

  for (genvar s = 0; s < SLOTS; s++) begin : gSlot
    localparam bit WANT_FP = (s != 0);
    logic slotBusy;
    assign slotWord[s] = fetchPacket[s*INSTR_W +: INSTR_W];
    assign dec[s]      = decodeSlot(slotWord[s]);
    always_comb begin
      if (dec[s].isFp)
        slotBusy = fpBusy[dec[s].srcA] | fpBusy[dec[s].srcB];
      else if (dec[s].isFpLoad)
        slotBusy = intBusy[dec[s].srcA];
      else
        slotBusy = intBusy[dec[s].srcA] | intBusy[dec[s].srcB];
    end
    assign classOkV[s] = (dec[s].isFp == WANT_FP);
    assign readyV[s]   = !slotBusy;
  end

  // only an FP load on the integer side writes the file the FP slot reads
  assign crossDep = dec[0].isFpLoad &&
                    ((dec[0].dst == dec[1].srcA) || (dec[0].dst == dec[1].srcB));

  assign flags = '{present: slotValid, classOk: classOkV,
                   srcReady: readyV, crossDep: crossDep};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intIssueValid <= 1'b0;
      fpIssueValid  <= 1'b0;
      intIssueInstr <= '0;
      fpIssueInstr  <= '0;
    end else begin
      intIssueValid <= strobe.loadInt;
      fpIssueValid  <= strobe.loadFp;
      if (strobe.loadInt) intIssueInstr <= slotWord[0];
      if (strobe.loadFp)  fpIssueInstr  <= slotWord[1];
    end
  end

  AST_INT_SRC_READY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadInt && !dec[0].isFpLoad |-> !intBusy[dec[0].srcA] && !intBusy[dec[0].srcB]); // R7
  AST_LOAD_BASE_READY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadInt && dec[0].isFpLoad |-> !intBusy[dec[0].srcA]); // R7
  AST_FP_SRC_READY: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFp |-> !fpBusy[dec[1].srcA] && !fpBusy[dec[1].srcB]); // R7
  AST_PAIR_NO_RAW: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFp && dec[0].isFpLoad |-> dec[0].dst != dec[1].srcA && dec[0].dst != dec[1].srcB); // R8
  AST_SLOT0_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadInt |-> !dec[0].isFp && slotValid[0]); // R6
  AST_SLOT1_CLASS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFp |-> dec[1].isFp && slotValid[1]); // R6
endmodule

// File: rtl/pair_control.sv
module pair_control
  import pair_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  pairFlags_t   flags,
  output issueStrobe_t strobe,
  output logic [1:0]   issueCount
);
  logic issueFirst;
  logic issueSecond;

  always_comb begin
    issueFirst  = flags.present[0] && flags.classOk[0] && flags.srcReady[0];
    issueSecond = issueFirst && flags.present[1] && flags.classOk[1] &&
                  flags.srcReady[1] && !flags.crossDep;
    strobe.loadInt = issueFirst;
    strobe.loadFp  = issueSecond;
    issueCount     = {1'b0, issueFirst} + {1'b0, issueSecond};
  end

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    issueCount != 2'd3); // R11
  AST_NO_FIRST_NO_ISSUE: assert property (@(posedge clk) disable iff (!rstN)
    !flags.present[0] |-> issueCount == 2'd0); // R10
endmodule

// File: rtl/pair_issue.sv
module pair_issue
  import pair_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic [SLOTS-1:0]    slotValid,
  input  logic [PACKET_W-1:0] fetchPacket,
  input  logic [NUM_REGS-1:0] intBusy,
  input  logic [NUM_REGS-1:0] fpBusy,
  output logic [1:0]          issueCount,
  output logic                intIssueValid,
  output logic [INSTR_W-1:0]  intIssueInstr,
  output logic                fpIssueValid,
  output logic [INSTR_W-1:0]  fpIssueInstr
);
  pairFlags_t   flags;
  issueStrobe_t strobe;

  pair_datapath uDp (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .fetchPacket(fetchPacket),
    .intBusy(intBusy), .fpBusy(fpBusy), .strobe(strobe), .flags(flags),
    .intIssueValid(intIssueValid), .intIssueInstr(intIssueInstr),
    .fpIssueValid(fpIssueValid), .fpIssueInstr(fpIssueInstr)
  );

  pair_control uCtl (
    .clk(clk), .rstN(rstN), .flags(flags), .strobe(strobe), .issueCount(issueCount)
  );

  AST_SECOND_NEEDS_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    fpIssueValid |-> intIssueValid); // R5
  AST_DUAL_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    issueCount == 2'd2 |=> intIssueValid && fpIssueValid); // R11
  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    issueCount == 2'd0 |=> !intIssueValid && !fpIssueValid); // R11
endmodule

// File: tb/sim_pair_issue.sv
module sim_pair_issue;
  import pair_pkg::*;

  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic [SLOTS-1:0]    slotValid = '0;
  logic [PACKET_W-1:0] fetchPacket = '0;
  logic [NUM_REGS-1:0] intBusy = '0;
  logic [NUM_REGS-1:0] fpBusy = '0;
  logic [1:0]          issueCount;
  logic                intIssueValid, fpIssueValid;
  logic [INSTR_W-1:0]  intIssueInstr, fpIssueInstr;

  int  nChecks = 0;
  int  nFails = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pair_issue u0 (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .fetchPacket(fetchPacket),
    .intBusy(intBusy), .fpBusy(fpBusy), .issueCount(issueCount),
    .intIssueValid(intIssueValid), .intIssueInstr(intIssueInstr),
    .fpIssueValid(fpIssueValid), .fpIssueInstr(fpIssueInstr)
  );

  // R2 encodings: bit31 FP class, bit31=0 & bit30=1 FP load, else integer ALU
  localparam logic [5:0] OP_INT = 6'b000011;
  localparam logic [5:0] OP_LD  = 6'b010000;
  localparam logic [5:0] OP_FP  = 6'b100101;

  function automatic logic [31:0] mk(input logic [5:0] op, input int d, input int a, input int b);
    return {op, d[4:0], a[4:0], b[4:0], 11'h155};
  endfunction

  function automatic logic [31:0] bit1(input int n);
    return 32'd1 << n;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drives one packet, checks the same-cycle count, then the registered pipe side
  task automatic present(input string tag, input logic [1:0] v, input logic [31:0] s0,
                         input logic [31:0] s1, input logic [31:0] ib, input logic [31:0] fb,
                         input int expCnt);
    @(negedge clk);
    slotValid = v; fetchPacket = {s1, s0}; intBusy = ib; fpBusy = fb;
    #2;
    chk({tag, " count"}, 32'(issueCount), 32'(expCnt));
    @(negedge clk);
    chk({tag, " intValid"}, 32'(intIssueValid), 32'(expCnt >= 1));
    chk({tag, " fpValid"}, 32'(fpIssueValid), 32'(expCnt == 2));
    if (expCnt >= 1) chk({tag, " intInstr"}, intIssueInstr, s0);
    if (expCnt == 2) chk({tag, " fpInstr"}, fpIssueInstr, s1);
    slotValid = '0; intBusy = '0; fpBusy = '0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {30'd0, intIssueValid, fpIssueValid}, 32'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid after reset", {30'd0, intIssueValid, fpIssueValid}, 32'd0);
    chk("R1 count after reset", 32'(issueCount), 32'd0);
  endtask

  task automatic t_pair();
    present("R3 R4 int+fp pair", 2'b11, mk(OP_INT, 1, 2, 3), mk(OP_FP, 4, 5, 6), '0, '0, 2);
  endtask

  task automatic t_single();
    present("R3 R10 slot1 invalid", 2'b01, mk(OP_INT, 7, 8, 9), mk(OP_FP, 4, 5, 6), '0, '0, 1);
    present("R10 slot0 invalid", 2'b10, mk(OP_INT, 7, 8, 9), mk(OP_FP, 4, 5, 6), '0, '0, 0);
    present("R11 idle drops valids", 2'b00, mk(OP_INT, 7, 8, 9), mk(OP_FP, 4, 5, 6), '0, '0, 0);
  endtask

  task automatic t_class();
    present("R6 int in slot1", 2'b11, mk(OP_INT, 1, 2, 3), mk(OP_INT, 4, 5, 6), '0, '0, 1);
    present("R6 fp in slot0", 2'b11, mk(OP_FP, 1, 2, 3), mk(OP_FP, 4, 5, 6), '0, '0, 0);
  endtask

  task automatic t_busy();
    present("R5 R7 int srcB busy", 2'b11, mk(OP_INT, 1, 2, 3), mk(OP_FP, 4, 5, 6), bit1(3), '0, 0);
    present("R7 int srcA busy", 2'b01, mk(OP_INT, 1, 2, 3), 32'd0, bit1(2), '0, 0);
    present("R7 fp srcA busy", 2'b11, mk(OP_INT, 1, 2, 3), mk(OP_FP, 4, 5, 6), '0, bit1(5), 1);
    present("R7 fp srcB busy", 2'b11, mk(OP_INT, 1, 2, 3), mk(OP_FP, 4, 5, 6), '0, bit1(6), 1);
    present("R7 load ignores srcB", 2'b11, mk(OP_LD, 8, 1, 12), mk(OP_FP, 9, 10, 11), bit1(12), '0, 2);
    present("R7 load base busy", 2'b11, mk(OP_LD, 8, 1, 12), mk(OP_FP, 9, 10, 11), bit1(1), '0, 0);
    present("R7 int busy other file", 2'b11, mk(OP_INT, 1, 2, 3), mk(OP_FP, 4, 5, 6), '0, bit1(2) | bit1(3), 2);
  endtask

  task automatic t_load_pair();
    present("R8 load+fp independent", 2'b11, mk(OP_LD, 8, 1, 0), mk(OP_FP, 9, 10, 11), '0, '0, 2);
    present("R8 fp reads load dst A", 2'b11, mk(OP_LD, 8, 1, 0), mk(OP_FP, 9, 8, 11), '0, '0, 1);
    present("R8 fp reads load dst B", 2'b11, mk(OP_LD, 8, 1, 0), mk(OP_FP, 9, 10, 8), '0, '0, 1);
  endtask

  task automatic t_cross_file();
    present("R9 int dst same number", 2'b11, mk(OP_INT, 5, 2, 3), mk(OP_FP, 4, 5, 5), '0, '0, 2);
  endtask

  initial begin
    t_reset();
    t_pair();
    t_single();
    t_class();
    t_busy();
    t_load_pair();
    t_cross_file();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule